// File: doc/BRIEF.md
# Masked SIMD Linear Compare Array

This block is a row of N identical processing elements, with N a power of two. A shared controller drives them all from one instruction stream. Each element owns two data words, called A and R. It can reach only the element directly to its left and the element directly to its right. On each step the controller broadcasts one opcode, one routing side and one three-valued activation mask. Every element compares its own index with the mask and either carries out the step or holds still.

There are three operations. Compare-exchange orders an element's two words as unsigned values. Route pulls the R word of the neighbour on the chosen side. Exchange swaps A and R. The array has a parallel port that loads every A and R word in one clock. It also shows every word on flat output buses, so a merge or sort sequencer can set up data and read back the result. An element at either end has no neighbour on one side. When it routes from that missing side, it takes a fixed fill word, which by default is the largest value.

Top module: `lin_pe_array`

## Requirements
- R1: After reset every A and R word reads zero and `done` is low.
- R2: While `load_en` is high, the next clock edge writes every A word from `load_a` and every R word from `load_r` (element i in bits [i*W +: W]). Load wins over an instruction given in the same cycle.
- R3: Opcode 0 (compare-exchange) leaves, in each active element, the smaller of A and R in R and the larger in A, with the words compared as unsigned numbers.
- R4: Opcode 1 (route) with `route_from_right` = 0 copies the R word of element i-1 into the R word of element i. With `route_from_right` = 1 it copies from element i+1. All elements use the values from before the step, and A is left untouched.
- R5: An element with no neighbour on the routed side loads the fill word (default all ones) into R.
- R6: Opcode 2 (exchange) swaps A and R in each active element.
- R7: Element i is active only when, for every bit b with `mask_care[b]` = 1, bit b of i equals `mask_val[b]`. Bits with `mask_care[b]` = 0 are don't-care.
- R8: An inactive element keeps both of its words, and opcode 3 changes nothing in any element.
- R9: `done` is high for exactly the one cycle after each cycle in which `instr_valid` is high.
- R10: While `instr_valid` is low, the opcode, side and mask inputs change no word and raise no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Strobe that applies the broadcast instruction this cycle |
| instr_op | input | 2 | 0 compare-exchange, 1 route, 2 exchange, 3 no operation |
| route_from_right | input | 1 | Route side: 0 pulls from element i-1, 1 from element i+1 |
| mask_care | input | log2(N) | 1 where the address bit must match |
| mask_val | input | log2(N) | Required address bit value where cared |
| load_en | input | 1 | Parallel load of all words |
| load_a | input | N*W | A words to load |
| load_r | input | N*W | R words to load |
| out_a | output | N*W | Current A words |
| out_r | output | N*W | Current R words |
| done | output | 1 | One-cycle pulse after each strobe |

## Verification
The bench covers routing in both directions. It checks that element 0 or element N-1 picks up the fill word and not a stale or wrapped-around value. A design that wraps the ends around, or leaves R unchanged there, shows a wrong end word. Masks are tested with even elements only, the upper half only, and a single address, so an inverted or dropped care bit shows up as the wrong set of elements changing. Compare-exchange runs on words that include 0 and all ones, which catches a signed compare or swapped min and max outputs. The bench also gives an instruction in the same cycle as a load, and sets opcode inputs with no strobe, to expose a wrong priority or a missing valid qualifier.

// File: rtl/lpa_pkg.sv
package lpa_pkg;
   typedef enum logic [1:0] {
      OP_CMPX  = 2'd0,
      OP_ROUTE = 2'd1,
      OP_SWAP  = 2'd2,
      OP_IDLE  = 2'd3
   } pe_op_e;
endpackage

// File: rtl/pe_match.sv
module pe_match #(
   parameter int AW   = 3,
   parameter int ADDR = 0
) (
   input  logic [AW-1:0] care,
   input  logic [AW-1:0] val,
   output logic          hit
);
   localparam logic [AW-1:0] ABITS = AW'(ADDR);
   logic [AW-1:0] bit_ok;

   generate
      for (genvar b = 0; b < AW; b++) begin : g_bit
         assign bit_ok[b] = ~care[b] | (val[b] == ABITS[b]);
      end
   endgenerate

   assign hit = &bit_ok;

   // R7
   always_comb begin
      if (care == '0) wildcard_hit_chk: assert (hit);
   end
endmodule

// File: rtl/pe_cell.sv
module pe_cell
   import lpa_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         act,
   input  pe_op_e       op,
   input  logic         from_right,
   input  logic [W-1:0] nbr_l,
   input  logic [W-1:0] nbr_r,
   input  logic         load,
   input  logic [W-1:0] ld_a,
   input  logic [W-1:0] ld_r,
   output logic [W-1:0] a_q,
   output logic [W-1:0] r_q
);
   logic [W-1:0] a_d, r_d;

   always_comb begin
      a_d = a_q;
      r_d = r_q;
      if (load) begin
         a_d = ld_a;
         r_d = ld_r;
      end else if (act) begin
         unique case (op)
            OP_CMPX: begin
               if (a_q < r_q) begin
                  r_d = a_q;
                  a_d = r_q;
               end
            end
            OP_ROUTE: r_d = from_right ? nbr_r : nbr_l;
            OP_SWAP: begin
               a_d = r_q;
               r_d = a_q;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         r_q <= '0;
      end else begin
         a_q <= a_d;
         r_q <= r_d;
      end
   end

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!act && !load) |=> ($stable(a_q) && $stable(r_q)));
   // R3
   cmpx_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !load && op == OP_CMPX) |=> (r_q <= a_q));
   // R6
   swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !load && op == OP_SWAP) |=> (a_q == $past(r_q) && r_q == $past(a_q)));
   // R4
   route_keep_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !load && op == OP_ROUTE) |=> $stable(a_q));
   // R2
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (a_q == $past(ld_a) && r_q == $past(ld_r)));
endmodule

// File: rtl/lin_pe_array.sv
module lin_pe_array
   import lpa_pkg::*;
#(
   parameter int          N    = 8,
   parameter int          W    = 8,
   parameter logic [W-1:0] FILL = '1,
   localparam int          AW   = $clog2(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            instr_valid,
   input  logic [1:0]      instr_op,
   input  logic            route_from_right,
   input  logic [AW-1:0]   mask_care,
   input  logic [AW-1:0]   mask_val,
   input  logic            load_en,
   input  logic [N*W-1:0]  load_a,
   input  logic [N*W-1:0]  load_r,
   output logic [N*W-1:0]  out_a,
   output logic [N*W-1:0]  out_r,
   output logic            done
);
   generate
      if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_n
         $error("lin_pe_array: N must be a power of two and at least 2");
      end
      if (W < 1) begin : g_bad_w
         $error("lin_pe_array: W must be positive");
      end
   endgenerate

   pe_op_e       op;
   logic [W-1:0] a_w [N];
   logic [W-1:0] r_w [N];
   logic [N-1:0] act;

   assign op = pe_op_e'(instr_op);

   generate
      for (genvar i = 0; i < N; i++) begin : g_pe
         logic         hit;
         logic [W-1:0] left_src, right_src;

         pe_match #(.AW(AW), .ADDR(i)) u_match (
            .care (mask_care),
            .val  (mask_val),
            .hit  (hit)
         );
         assign act[i] = instr_valid & hit;

         if (i == 0) begin : g_lend
            assign left_src = FILL;
         end else begin : g_lmid
            assign left_src = r_w[i-1];
         end
         if (i == N - 1) begin : g_rend
            assign right_src = FILL;
         end else begin : g_rmid
            assign right_src = r_w[i+1];
         end

         pe_cell #(.W(W)) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .act        (act[i]),
            .op         (op),
            .from_right (route_from_right),
            .nbr_l      (left_src),
            .nbr_r      (right_src),
            .load       (load_en),
            .ld_a       (load_a[i*W +: W]),
            .ld_r       (load_r[i*W +: W]),
            .a_q        (a_w[i]),
            .r_q        (r_w[i])
         );
         assign out_a[i*W +: W] = a_w[i];
         assign out_r[i*W +: W] = r_w[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done <= 1'b0;
      else        done <= instr_valid;
   end

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid |=> done);
   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> !done);
   // R5
   left_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act[0] && !load_en && op == OP_ROUTE && !route_from_right) |=> (r_w[0] == FILL));
   // R5
   right_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act[N-1] && !load_en && op == OP_ROUTE && route_from_right) |=> (r_w[N-1] == FILL));
   // R4
   route_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act[1] && !load_en && op == OP_ROUTE && !route_from_right) |=> (r_w[1] == $past(r_w[0])));
endmodule

// File: tb/lin_pe_array_test.sv
`timescale 1ns/1ps
module lin_pe_array_test;
   localparam int N  = 8;
   localparam int W  = 8;
   localparam int AW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic instr_valid = 1'b0;
   logic [1:0] instr_op = 2'd3;
   logic route_from_right = 1'b0;
   logic [AW-1:0] mask_care = '0, mask_val = '0;
   logic load_en = 1'b0;
   logic [N*W-1:0] load_a = '0, load_r = '0;
   logic [N*W-1:0] out_a, out_r;
   logic done;

   int tests = 0, fails = 0;
   bit finished = 0;

   logic [W-1:0] ma [N];
   logic [W-1:0] mr [N];
   logic [N*W-1:0] exp_a_q [$];
   logic [N*W-1:0] exp_r_q [$];
   string tag_q [$];

   always #2.5 clk = ~clk;

   lin_pe_array #(.N(N), .W(W)) uut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
      .route_from_right(route_from_right), .mask_care(mask_care), .mask_val(mask_val),
      .load_en(load_en), .load_a(load_a), .load_r(load_r),
      .out_a(out_a), .out_r(out_r), .done(done));

   function automatic logic [N*W-1:0] pack_a();
      logic [N*W-1:0] v;
      for (int i = 0; i < N; i++) v[i*W +: W] = ma[i];
      return v;
   endfunction
   function automatic logic [N*W-1:0] pack_r();
      logic [N*W-1:0] v;
      for (int i = 0; i < N; i++) v[i*W +: W] = mr[i];
      return v;
   endfunction
   function automatic bit is_act(int i, logic [AW-1:0] c, logic [AW-1:0] v);
      for (int b = 0; b < AW; b++)
         if (c[b] && (v[b] != i[b])) return 0;
      return 1;
   endfunction

   task automatic check(string tag, logic [N*W-1:0] act_v, logic [N*W-1:0] exp_v);
      tests++;
      if (act_v !== exp_v) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
      end
   endtask

   // monitor: pops one expected snapshot per done pulse
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (tag_q.size() == 0) begin
            tests++; fails++;
            $display("FAIL R9 actual=done-without-strobe expected=no-done");
         end else begin
            string t;
            logic [N*W-1:0] ea, er;
            t = tag_q.pop_front(); ea = exp_a_q.pop_front(); er = exp_r_q.pop_front();
            check({t, " A"}, out_a, ea);
            check({t, " R"}, out_r, er);
         end
      end
   end

   task automatic do_load(logic [N*W-1:0] va, logic [N*W-1:0] vr);
      @(negedge clk);
      load_en = 1'b1; load_a = va; load_r = vr;
      for (int i = 0; i < N; i++) begin ma[i] = va[i*W +: W]; mr[i] = vr[i*W +: W]; end
      @(negedge clk);
      load_en = 1'b0;
      check("R2 load A", out_a, pack_a());
      check("R2 load R", out_r, pack_r());
      check("R9 no done on load", {{(N*W-1){1'b0}}, done}, '0);
   endtask

   task automatic do_instr(logic [1:0] op, logic dir, logic [AW-1:0] c,
                           logic [AW-1:0] v, string tag);
      logic [W-1:0] or_ [N];
      @(negedge clk);
      instr_valid = 1'b1; instr_op = op; route_from_right = dir;
      mask_care = c; mask_val = v;
      for (int i = 0; i < N; i++) or_[i] = mr[i];
      for (int i = 0; i < N; i++) begin
         if (is_act(i, c, v)) begin
            logic [W-1:0] t;
            case (op)
               2'd0: if (ma[i] < mr[i]) begin t = ma[i]; ma[i] = mr[i]; mr[i] = t; end
               2'd1: begin
                  if (dir) mr[i] = (i == N-1) ? {W{1'b1}} : or_[i+1];
                  else     mr[i] = (i == 0)   ? {W{1'b1}} : or_[i-1];
               end
               2'd2: begin t = ma[i]; ma[i] = mr[i]; mr[i] = t; end
               default: ;
            endcase
         end
      end
      exp_a_q.push_back(pack_a()); exp_r_q.push_back(pack_r()); tag_q.push_back(tag);
      @(negedge clk);
      instr_valid = 1'b0;
   endtask

   initial begin
      #200000;
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin ma[i] = '0; mr[i] = '0; end
      repeat (3) @(negedge clk);
      check("R1 reset A", out_a, '0);
      check("R1 reset R", out_r, '0);
      check("R1 reset done", {{(N*W-1){1'b0}}, done}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      do_load(64'h00_FF_10_80_7F_01_33_44, 64'hFF_00_20_7F_80_02_33_40);
      do_instr(2'd0, 1'b0, 3'b000, 3'b000, "R3 cmpx all");
      do_instr(2'd1, 1'b0, 3'b000, 3'b000, "R4 R5 route from left");
      do_instr(2'd1, 1'b1, 3'b000, 3'b000, "R4 R5 route from right");
      do_instr(2'd2, 1'b0, 3'b001, 3'b000, "R6 R7 swap even elements");
      do_instr(2'd2, 1'b0, 3'b111, 3'b101, "R7 swap element 5 only");
      do_load(64'h01_02_03_04_F0_E0_D0_C0, 64'hC0_D0_E0_F0_04_03_02_01);
      do_instr(2'd0, 1'b0, 3'b100, 3'b100, "R3 R7 cmpx upper half");
      do_instr(2'd3, 1'b0, 3'b000, 3'b000, "R8 opcode 3 no change");
      do_instr(2'd1, 1'b1, 3'b001, 3'b001, "R5 R8 route right odd only");

      // R10: inputs without strobe change nothing
      @(negedge clk);
      instr_op = 2'd2; mask_care = '0;
      @(negedge clk);
      check("R10 no strobe A", out_a, pack_a());
      check("R10 no strobe R", out_r, pack_r());
      check("R10 no done", {{(N*W-1){1'b0}}, done}, '0);

      // R2: load beats a same-cycle instruction
      @(negedge clk);
      load_en = 1'b1; load_a = {8{8'h5A}}; load_r = {8{8'hA5}};
      instr_valid = 1'b1; instr_op = 2'd2; mask_care = '0;
      for (int i = 0; i < N; i++) begin ma[i] = 8'h5A; mr[i] = 8'hA5; end
      exp_a_q.push_back(pack_a()); exp_r_q.push_back(pack_r()); tag_q.push_back("R2 load priority");
      @(negedge clk);
      load_en = 1'b0; instr_valid = 1'b0;

      repeat (4) @(negedge clk);
      check("R9 all done pulses seen", {{(N*W-32){1'b0}}, 32'(tag_q.size())}, '0);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule